// File: doc/BRIEF.md
# JTAG Test Access Port with Auxiliary Port Sharing

This block is an IEEE 1149.1 test access port controller that lives in the system clock domain. It oversamples the TCK, TMS and TDI pins through a synchronizer, runs the 16-state TAP state machine on the rising TCK edges it detects, and drives TDO and its output enable on the falling edges. The master holds a 5-bit instruction register and a one-bit bypass register. Every opcode other than the four access opcodes behaves as bypass.

Loading one of the four access opcodes hands the port to one auxiliary TAP controller. From then on the pin TMS and TDI are forwarded to that controller, along with a registered copy of TCK, and its TDO is driven out on the pin. The master keeps following the pin TMS so that it always knows the TAP state. It takes the port back at Update-DR of a data scan that went through Pause-DR, or when it enters Test-Logic-Reset. An auxiliary that does not own the port sees TMS and TDI held low, which parks it in Run-Test/Idle.

TCK has to run below a quarter of the system clock, so that each TCK level lasts for at least two samples.

Top module: `jps_port_share`

## Requirements
- R1: After system reset, the port belongs to the master, the instruction is BYPASS (5'b11111), tdo_oe is low, and aux_tck, aux_tms and aux_tdi are all low.
- R2: Five TCK rising edges with TMS high bring the TAP to Test-Logic-Reset from any state, and tdo_oe is then low.
- R3: tdo_oe and tdo change only after a falling TCK edge. tdo_oe is high exactly when the TAP is in Shift-IR or Shift-DR.
- R4: Capture-IR loads 5'b00001. During Shift-IR, tdo shows the shift register LSB first, and TDI enters at the MSB.
- R5: With the master owning the port in a data scan, Capture-DR clears the bypass bit. Each Shift-DR edge loads TDI into it, so tdo repeats TDI one TCK later.
- R6: An instruction update with opcode 5'b10000+k, for k = 0..3, grants the port to auxiliary k. Any other opcode leaves the port with the master in bypass.
- R7: While auxiliary k owns the port, aux_tms[k] and aux_tdi[k] follow the pin TMS and TDI. aux_tck follows TCK. During Shift states, tdo carries aux_tdo[k] as sampled at the falling TCK edge.
- R8: Every auxiliary that does not own the port has its aux_tms and aux_tdi held low, and at most one aux_tms bit is high at any time.
- R9: While an auxiliary owns the port, instruction scans do not change the master instruction register, and they neither change nor drop the ownership.
- R10: Ownership returns to the master, with the instruction set to BYPASS, at Update-DR of a data scan that entered Pause-DR. A data scan with no pause keeps the auxiliary as owner.
- R11: Entering Test-Logic-Reset returns the port to the master and sets the instruction to BYPASS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Test clock pin |
| tms | input | 1 | Test mode select pin |
| tdi | input | 1 | Test data in pin |
| tdo | output | 1 | Test data out pin value |
| tdo_oe | output | 1 | Output enable for the TDO pad |
| aux_tck | output | 1 | Test clock copy for the auxiliary controllers |
| aux_tms | output | N_AUX | Per-auxiliary TMS, low when that auxiliary is not the owner |
| aux_tdi | output | N_AUX | Per-auxiliary TDI, low when that auxiliary is not the owner |
| aux_tdo | input | N_AUX | TDO returned by each auxiliary controller |

## Verification
The hardest situation to reach from the pins is the return of ownership. It needs an access opcode shifted in exactly, and then a data scan that detours through Pause-DR, while the master's own registers must stay frozen throughout. The bench drives TAP-level tasks that build instruction and data scans with and without the pause, interleaved with raw TMS walks. It also runs an instruction scan in the middle of an auxiliary session and resets through five TMS-high edges while an auxiliary owns the port. A bench-side TAP model predicts the owner, TDO and the forwarded pins on every TCK.

// File: rtl/jps_pkg.sv
package jps_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    tap_state_e n;
    unique case (s)
      ST_TLR:    n = m ? ST_TLR    : ST_RTI;
      ST_RTI:    n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

  function automatic logic is_shift(tap_state_e s);
    return (s == ST_SH_IR) || (s == ST_SH_DR);
  endfunction

endpackage

// File: rtl/jps_pin_sync.sv
module jps_pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jps_tap_fsm.sv
module jps_tap_fsm
  import jps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tck_rise,
  input  logic       tms_s,
  output tap_state_e state
);
  always_ff @(posedge clk) begin
    if (rst)           state <= ST_TLR;
    else if (tck_rise) state <= tap_next(state, tms_s);
  end

  // consecutive TMS-high rising edges, saturating, for the reset check
  logic [2:0] ones_run;
  always_ff @(posedge clk) begin
    if (rst) ones_run <= '0;
    else if (tck_rise) ones_run <= tms_s ? ((ones_run == 3'd5) ? ones_run : ones_run + 3'd1) : 3'd0;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge clk) disable iff (rst)
    (ones_run == 3'd5) |-> (state == ST_TLR)); // R2
  AST_STATE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    !tck_rise |=> $stable(state)); // R3
endmodule

// File: rtl/jps_master_path.sv
module jps_master_path
  import jps_pkg::*;
#(
  parameter int IR_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tck_rise,
  input  logic            active,
  input  logic            force_bypass,
  input  logic            tdi_s,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            master_bit
);
  localparam logic [IR_W-1:0] IR_BYPASS = '1;
  localparam logic [IR_W-1:0] IR_CAPT   = IR_W'(1);

  logic [IR_W-1:0] ir_shift;
  logic            byp;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_shift <= '0;
      ir_q     <= IR_BYPASS;
      byp      <= 1'b0;
    end else begin
      if (state == ST_TLR || force_bypass)
        ir_q <= IR_BYPASS;
      else if (tck_rise && active && state == ST_UPD_IR)
        ir_q <= ir_shift;
      if (tck_rise && active) begin
        case (state)
          ST_CAP_IR: ir_shift <= IR_CAPT;
          ST_SH_IR:  ir_shift <= {tdi_s, ir_shift[IR_W-1:1]};
          ST_CAP_DR: byp      <= 1'b0;
          ST_SH_DR:  byp      <= tdi_s;
          default:   ;
        endcase
      end
    end
  end

  assign master_bit = (state == ST_SH_IR) ? ir_shift[0] : byp;

  AST_IR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!active && $past(!active)) |-> ($stable(ir_q) && $stable(ir_shift))); // R9
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (rst)
    (tck_rise && active && state == ST_CAP_IR) |=> (ir_shift == IR_CAPT)); // R4
endmodule

// File: rtl/jps_port_share.sv
module jps_port_share
  import jps_pkg::*;
#(
  parameter int N_AUX       = 4,
  parameter int IR_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             aux_tck,
  output logic [N_AUX-1:0] aux_tms,
  output logic [N_AUX-1:0] aux_tdi,
  input  logic [N_AUX-1:0] aux_tdo
);
  localparam int SEL_W = (N_AUX > 1) ? $clog2(N_AUX) : 1;
  localparam int HI_W  = IR_W - SEL_W;
  localparam logic [HI_W-1:0] ACCESS_HI = HI_W'(1) << (HI_W - 1);
  localparam int SW    = N_AUX + 3;

  // pin synchronizer and TCK edge detection
  logic [SW-1:0]    pins_s;
  logic             tck_s, tms_s, tdi_s, tck_q;
  logic [N_AUX-1:0] aux_tdo_s;
  logic             tck_rise, tck_fall;

  jps_pin_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({aux_tdo, tdi, tms, tck}), .q(pins_s)
  );
  assign {aux_tdo_s, tdi_s, tms_s, tck_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) tck_q <= 1'b0;
    else     tck_q <= tck_s;
  end
  assign tck_rise = tck_s & ~tck_q;
  assign tck_fall = ~tck_s & tck_q;

  // TAP state, tracked on the pin TMS regardless of owner
  tap_state_e state;
  jps_tap_fsm u_fsm (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .tms_s(tms_s), .state(state)
  );

  // ownership
  logic             own_v, pause_seen, reclaim;
  logic [SEL_W-1:0] own_sel;
  logic [IR_W-1:0]  ir_q;
  logic             master_bit;
  logic             sel_ok, access_ir;

  if (N_AUX == (1 << SEL_W)) begin : g_sel_full
    assign sel_ok = 1'b1;
  end else begin : g_sel_part
    assign sel_ok = (int'(ir_q[SEL_W-1:0]) < N_AUX);
  end
  assign access_ir = (ir_q[IR_W-1:SEL_W] == ACCESS_HI) && sel_ok;
  assign reclaim   = own_v && tck_rise && (state == ST_UPD_DR) && pause_seen;

  jps_master_path #(.IR_W(IR_W)) u_master (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .active(!own_v),
    .force_bypass(reclaim), .tdi_s(tdi_s), .state(state),
    .ir_q(ir_q), .master_bit(master_bit)
  );

  always_ff @(posedge clk) begin
    if (rst || state == ST_TLR) begin
      own_v      <= 1'b0;
      own_sel    <= '0;
      pause_seen <= 1'b0;
    end else if (!own_v) begin
      if (access_ir) begin
        own_v   <= 1'b1;
        own_sel <= ir_q[SEL_W-1:0];
      end
    end else if (tck_rise) begin
      case (state)
        ST_PAU_DR: pause_seen <= 1'b1;
        ST_CAP_DR: pause_seen <= 1'b0;
        ST_UPD_DR: if (pause_seen) begin
          own_v      <= 1'b0;
          pause_seen <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // auxiliary side: forwarded to the owner, parked low otherwise
  always_ff @(posedge clk) begin
    if (rst) aux_tck <= 1'b0;
    else     aux_tck <= tck_s;
  end

  for (genvar i = 0; i < N_AUX; i++) begin : g_aux
    logic mine;
    assign mine = own_v && (int'(own_sel) == i);
    always_ff @(posedge clk) begin
      if (rst) begin
        aux_tms[i] <= 1'b0;
        aux_tdi[i] <= 1'b0;
      end else begin
        aux_tms[i] <= mine & tms_s;
        aux_tdi[i] <= mine & tdi_s;
      end
    end
  end

  // pin TDO, updated on the falling TCK edge
  always_ff @(posedge clk) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else if (tck_fall) begin
      tdo_oe <= is_shift(state);
      if (!is_shift(state)) tdo <= 1'b0;
      else if (own_v)       tdo <= aux_tdo_s[own_sel];
      else                  tdo <= master_bit;
    end
  end

  AST_OE_IN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $rose(tdo_oe) |-> is_shift(state)); // R3
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(aux_tms) && $onehot0(aux_tdi)); // R8
  AST_PARKED: assert property (@(posedge clk) disable iff (rst)
    (!own_v && $past(!own_v)) |-> (aux_tms == '0 && aux_tdi == '0)); // R8
  AST_GRANT_AFTER_UIR: assert property (@(posedge clk) disable iff (rst)
    $rose(own_v) |-> (state == ST_RTI || state == ST_SEL_DR)); // R6
  AST_RECLAIM_PAUSED: assert property (@(posedge clk) disable iff (rst)
    $fell(own_v) |-> ($past(pause_seen) || $past(state) == ST_TLR)); // R10
endmodule

// File: tb/tb_jps_port_share.sv
module tb_jps_port_share;
  import jps_pkg::*;
  localparam int N = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic tck = 1'b0, tms = 1'b0, tdi = 1'b0;
  logic tdo, tdo_oe, aux_tck;
  logic [N-1:0] aux_tms, aux_tdi, aux_tdo = '0;

  always #2 clk = ~clk;

  jps_port_share #(.N_AUX(N), .IR_W(5), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .aux_tck(aux_tck), .aux_tms(aux_tms), .aux_tdi(aux_tdi), .aux_tdo(aux_tdo)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur = "R1";

  // bench model
  tap_state_e m_st = ST_TLR;
  logic [4:0] m_sr = '0, m_ir = 5'h1F;
  logic m_byp = 0, m_pause = 0, m_tdo = 0, m_oe = 0, p_tms = 0, p_tdi = 0;
  int m_own = -1;

  function automatic tap_state_e nxt(tap_state_e s, logic m);
    case (s)
      ST_TLR: return m ? ST_TLR : ST_RTI;
      ST_RTI, ST_UPD_DR, ST_UPD_IR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_SEL_IR: return m ? ST_TLR : ST_CAP_IR;
      ST_CAP_DR, ST_SH_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_CAP_IR, ST_SH_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      default:   return m ? ST_UPD_IR : ST_SH_IR;
    endcase
  endfunction

  task automatic model_rise(logic t, logic d);
    if (m_own < 0) begin
      case (m_st)
        ST_CAP_IR: m_sr = 5'b00001;
        ST_SH_IR:  m_sr = {d, m_sr[4:1]};
        ST_UPD_IR: begin
          m_ir = m_sr;
          if (m_sr[4:2] == 3'b100) m_own = int'(m_sr[1:0]);
        end
        ST_CAP_DR: m_byp = 1'b0;
        ST_SH_DR:  m_byp = d;
        default: ;
      endcase
    end else begin
      case (m_st)
        ST_PAU_DR: m_pause = 1'b1;
        ST_CAP_DR: m_pause = 1'b0;
        ST_UPD_DR: if (m_pause) begin m_own = -1; m_pause = 0; m_ir = 5'h1F; end
        default: ;
      endcase
    end
    m_st = nxt(m_st, t);
    if (m_st == ST_TLR) begin m_own = -1; m_pause = 0; m_ir = 5'h1F; end
  endtask

  task automatic model_fall(logic [N-1:0] a);
    m_oe = (m_st == ST_SH_IR) || (m_st == ST_SH_DR);
    if (!m_oe)           m_tdo = 1'b0;
    else if (m_own >= 0) m_tdo = a[m_own];
    else                 m_tdo = (m_st == ST_SH_IR) ? m_sr[0] : m_byp;
  endtask

  task automatic cmp(string what, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
    end
  endtask

  task automatic step(logic t, logic d);
    logic [N-1:0] a, et, ed;
    et = '0; ed = '0;
    if (m_own >= 0) begin et[m_own] = p_tms; ed[m_own] = p_tdi; end
    cmp("tdo_oe (R3)", 8'(tdo_oe), 8'(m_oe));
    if (m_oe) cmp("tdo", 8'(tdo), 8'(m_tdo));
    cmp("aux_tms (R7/R8)", 8'(aux_tms), 8'(et));
    cmp("aux_tdi (R7/R8)", 8'(aux_tdi), 8'(ed));
    cmp("aux_tck", 8'(aux_tck), 8'd0);
    a = N'($urandom);
    tms = t; tdi = d; aux_tdo = a;
    repeat (2) @(negedge clk);
    tck = 1'b1; model_rise(t, d);
    repeat (8) @(negedge clk);
    tck = 1'b0; model_fall(a);
    repeat (8) @(negedge clk);
    p_tms = t; p_tdi = d;
  endtask

  task automatic goto_rti();
    repeat (5) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic ir_scan(logic [4:0] op);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(i == 4, op[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic dr_scan(int len, logic pause);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < len; i++) step(i == len - 1, 1'($urandom));
    if (pause) begin step(0, 0); step(0, 0); step(1, 0); end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (6) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    cur = "R1";
    cmp("reset tdo_oe", 8'(tdo_oe), 8'd0);
    cmp("reset aux_tms", 8'(aux_tms), 8'd0);
    goto_rti();
    cur = "R4"; ir_scan(5'b00110);
    cur = "R5"; dr_scan(9, 1'b0);
    for (int k = 0; k < N; k++) begin
      cur = "R6";  ir_scan(5'b10000 | 5'(k));
      cmp("owner forwarded TMS", 8'(aux_tms), 8'd0);
      step(1, 1);
      cmp("grant to aux", 8'(aux_tms), 8'(1 << k));
      step(0, 0); step(0, 0); step(1, 0); step(1, 0); step(0, 0);
      cur = "R7";  dr_scan(7, 1'b0);
      cur = "R10"; dr_scan(4, 1'b0);
      cur = "R9";  ir_scan(5'b10010);
      cur = "R10"; dr_scan(6, 1'b1);
      cur = "R5";  dr_scan(5, 1'b0);
    end
    cur = "R6"; ir_scan(5'b10111); dr_scan(6, 1'b0);
    cur = "R11"; ir_scan(5'b10010);
    step(1, 0); step(0, 0); step(0, 0); step(0, 1);
    cur = "R2";
    repeat (5) step(1'b1, 1'b0);
    cmp("after five TMS-high edges", 8'(tdo_oe), 8'd0);
    cmp("owner released by reset", 8'(aux_tms), 8'd0);
    cur = "R11"; step(0, 0); dr_scan(5, 1'b0);
    cur = "R3";
    for (int it = 0; it < 200; it++) begin
      goto_rti();
      ir_scan(($urandom_range(0, 1) == 1) ? (5'b10000 | 5'($urandom_range(0, 3))) : 5'($urandom));
      for (int j = 0; j < int'($urandom_range(1, 3)); j++) begin
        if ($urandom_range(0, 3) == 0) ir_scan(5'($urandom));
        else dr_scan(int'($urandom_range(1, 6)), 1'($urandom));
      end
      for (int j = 0; j < int'($urandom_range(1, 8)); j++) step(1'($urandom), 1'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      n_bad++;
      $display("FAIL %s watchdog: actual %0d expected below %0d cycles", cur, cyc, 195000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule